// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a synthesizable model of a parallel NOR flash that responds to the common byte-wide command set. It sits on a plain synchronous bus with a request strobe, write enable, byte address, access size and 32-bit write data. It holds a small byte array organised as equal sectors. A write-phase machine interprets command bytes. The command that was written last decides what a read returns: array contents, the status byte, or an entry of the device query table.

The supported operations are array read, single program, immediate sector erase, status clear, status read, lock sequences that change nothing, counted buffered writes and query reads. Program and erase finish in zero time, so the ready bit of the status byte is set as soon as an operation is accepted. Read data is registered and appears on the cycle after the read request.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset every array byte reads 0xFF, the status byte is 0x00 and the block is in array-read mode.
- R2: In the idle phase, code 0x10 or 0x40 arms a program. The next write stores its data at its address, sets status bit 7 and returns to array-read mode. A read while the program is armed returns 0xFFFFFFFF.
- R3: Code 0x20 at once fills with 0xFF every byte of the sector that holds the address, and sets status bit 7. A following 0xD0 completes the erase and keeps status reads. A following 0xFF, or any other value, returns to array-read mode.
- R4: Code 0x50 clears the whole status byte and returns to array-read mode. No other write clears status bit 7.
- R5: Code 0x70 selects status reads and leaves the machine in the idle phase. Code 0x00 or 0xFF in the idle phase selects array reads.
- R6: Code 0x60 opens a lock sequence. A second write of 0xD0 or 0x01 closes it, sets status bit 7 and keeps status reads. A second write of 0xFF, or any other value, returns to array-read mode. Array contents never change.
- R7: Code 0xE8 sets status bit 7. The next write's low byte is a count N. The following N+1 writes store data and each sets status bit 7. A final 0xD0 completes the sequence with status reads kept. Any other final value returns to array-read mode.
- R8: While the command is 0x20, 0x60, 0x70 or 0xE8, a read returns the status byte in bits 7:0, with zeros above it.
- R9: Code 0x98 selects query reads. The index is address bits 7:0 shifted right by log2 of the bus width in bytes, and an index of 0x52 or more reads 0. Later writes other than 0xFF keep query mode, and 0xFF leaves it.
- R10: The query table holds "QRY" at 0x10–0x12, 0x01 at 0x13, 0x31 at 0x15, 0x45/0x55 at 0x1B/0x1C, 0x07 at 0x1F and 0x20, 0x0A at 0x21, 0x04 at 0x23–0x25, and log2 of the device size at 0x27. It also holds 0x02 at 0x28, 0x0B at 0x2A, 0x01 at 0x2C, the sector count minus one at 0x2D–0x2E, the sector size over 256 at 0x2F–0x30, and "PRI11" at 0x31–0x35. Every other entry is 0.
- R11: Size code 0 moves one byte, 1 moves two and 2 or 3 moves four. Bytes are little-endian, with the lowest address in bits 7:0, and read lanes beyond the size are zero.
- R12: An idle-phase code outside the set above selects array reads and leaves the status byte unchanged. So does an out-of-sequence value in a later phase, except where R9 keeps query mode.
- R13: Read data updates only on the cycle after a read request and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| size_i | input | 2 | Access size code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| addr_i | input | 10 | Byte address (log2 of total array bytes) |
| wdata_i | input | 32 | Write data; bits 7:0 carry command codes |
| rdata_o | output | 32 | Registered read data |

## Verification
A wrong phase or command register shows up on the very next read, one cycle after the request. Status bytes or query entries come back where array data is expected, or the reverse, and the all-ones pattern appears while a program is armed. A miscounted buffered write misplaces the confirm. The extra data write then lands in the array, or the confirm becomes an abort, and both are visible through later status and array reads. Erase or program lane errors stay in the array until the locations are read back, so the sequence reads neighbours in the same sector and in the next one.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ARG     = 2'd1,
    PH_DATA    = 2'd2,
    PH_CONFIRM = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    RS_ARRAY,
    RS_STATUS,
    RS_QUERY,
    RS_ONES
  } rsel_e;

  localparam logic [7:0] OP_NULL    = 8'h00;
  localparam logic [7:0] OP_ALT     = 8'h01;
  localparam logic [7:0] OP_PROG_A  = 8'h10;
  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG_B  = 8'h40;
  localparam logic [7:0] OP_CLR     = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h60;
  localparam logic [7:0] OP_STAT    = 8'h70;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_CONFIRM = 8'hD0;
  localparam logic [7:0] OP_BUF     = 8'hE8;
  localparam logic [7:0] OP_ARRAY   = 8'hFF;

  localparam logic [7:0] ST_READY = 8'h80;
  localparam logic [7:0] QRY_LEN  = 8'h52;

  function automatic logic idle_op_known(input logic [7:0] v);
    return v inside {OP_NULL, OP_PROG_A, OP_PROG_B, OP_ERASE, OP_CLR, OP_LOCK,
                     OP_STAT, OP_QUERY, OP_BUF, OP_ARRAY};
  endfunction

  function automatic logic [2:0] span_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_flash_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       code_i,
  input  logic [CNT_W-1:0] cnt_i,
  output phase_e           phase_o,
  output logic [7:0]       cmd_o,
  output logic [7:0]       status_o,
  output logic             prog_o,
  output logic             erase_o,
  output rsel_e            rsel_o
);

  phase_e           phase_q, phase_d;
  logic [7:0]       cmd_q, cmd_d;
  logic [7:0]       status_q, status_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             to_array;

  always_comb begin
    phase_d  = phase_q;
    cmd_d    = cmd_q;
    status_d = status_q;
    cnt_d    = cnt_q;
    prog_o   = 1'b0;
    erase_o  = 1'b0;
    to_array = 1'b0;
    if (wr_i) begin
      unique case (phase_q)
        PH_IDLE: begin
          case (code_i)
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmd_d   = code_i;
              phase_d = PH_ARG;
            end
            OP_ERASE: begin
              erase_o  = 1'b1;
              status_d = status_q | ST_READY;
              cmd_d    = code_i;
              phase_d  = PH_ARG;
            end
            OP_BUF: begin
              status_d = status_q | ST_READY;
              cmd_d    = code_i;
              phase_d  = PH_ARG;
            end
            OP_CLR: begin
              status_d = '0;
              to_array = 1'b1;
            end
            OP_STAT: cmd_d = code_i;
            default: to_array = 1'b1;
          endcase
        end
        PH_ARG: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              prog_o   = 1'b1;
              status_d = status_q | ST_READY;
              to_array = 1'b1;
            end
            OP_ERASE: begin
              if (code_i == OP_CONFIRM) begin
                phase_d  = PH_IDLE;
                status_d = status_q | ST_READY;
              end else begin
                to_array = 1'b1;
              end
            end
            OP_LOCK: begin
              if (code_i == OP_CONFIRM || code_i == OP_ALT) begin
                phase_d  = PH_IDLE;
                status_d = status_q | ST_READY;
              end else begin
                to_array = 1'b1;
              end
            end
            OP_QUERY: if (code_i == OP_ARRAY) to_array = 1'b1;
            OP_BUF: begin
              cnt_d   = cnt_i;
              phase_d = PH_DATA;
            end
            default: to_array = 1'b1;
          endcase
        end
        PH_DATA: begin
          if (cmd_q == OP_BUF) begin
            prog_o   = 1'b1;
            status_d = status_q | ST_READY;
            if (cnt_q == '0) phase_d = PH_CONFIRM;
            cnt_d = cnt_q - 1'b1;
          end else begin
            to_array = 1'b1;
          end
        end
        PH_CONFIRM: begin
          if (cmd_q == OP_BUF && code_i == OP_CONFIRM) begin
            phase_d  = PH_IDLE;
            status_d = status_q | ST_READY;
          end else begin
            to_array = 1'b1;
          end
        end
      endcase
      if (to_array) begin
        cmd_d   = OP_NULL;
        phase_d = PH_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= PH_IDLE;
      cmd_q    <= OP_NULL;
      status_q <= '0;
      cnt_q    <= '0;
    end else begin
      phase_q  <= phase_d;
      cmd_q    <= cmd_d;
      status_q <= status_d;
      cnt_q    <= cnt_d;
    end
  end

  always_comb begin
    case (cmd_q)
      OP_NULL:                                 rsel_o = RS_ARRAY;
      OP_ERASE, OP_CLR, OP_LOCK, OP_STAT, OP_BUF: rsel_o = RS_STATUS;
      OP_QUERY:                                rsel_o = RS_QUERY;
      default:                                 rsel_o = RS_ONES;
    endcase
  end

  assign phase_o  = phase_q;
  assign cmd_o    = cmd_q;
  assign status_o = status_q;

endmodule

// File: rtl/nor_byte_store.sv
module nor_byte_store
  import nor_flash_pkg::*;
#(
  parameter int SECTOR_BYTES = 256,
  parameter int SECTOR_COUNT = 4,
  localparam int TOTAL  = SECTOR_BYTES * SECTOR_COUNT,
  localparam int ADDR_W = $clog2(TOTAL),
  localparam int SEC_W  = $clog2(SECTOR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_i,
  input  logic              erase_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rd_o
);

  logic [8*TOTAL-1:0] flat;
  logic [7:0]         wbyte [4];
  logic [2:0]         span;

  assign span = span_bytes(size_i);

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [ADDR_W-1:0] ra;
    assign wbyte[k] = wdata_i[8*k +: 8];
    assign ra = addr_i + ADDR_W'(k);
    assign rd_o[8*k +: 8] = (3'(k) < span) ? flat[{ra, 3'b000} +: 8] : 8'h00;
  end

  for (genvar i = 0; i < TOTAL; i++) begin : g_byte
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(i);
    logic [ADDR_W-1:0] off;
    logic              in_sec;
    logic [7:0]        q;

    assign off    = MY_ADDR - addr_i;
    assign in_sec = (MY_ADDR >> SEC_W) == (addr_i >> SEC_W);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                q <= 8'hFF;
      else if (erase_i && in_sec)                 q <= 8'hFF;
      else if (prog_i && (off < ADDR_W'(span)))   q <= wbyte[off[1:0]];
    end

    assign flat[8*i +: 8] = q;
  end

endmodule

// File: rtl/nor_query_rom.sv
module nor_query_rom
  import nor_flash_pkg::*;
#(
  parameter int SECTOR_BYTES = 256,
  parameter int SECTOR_COUNT = 4,
  parameter int BUS_BYTES    = 2
) (
  input  logic [7:0] addr_lo_i,
  output logic [7:0] data_o
);

  localparam int          TOTAL = SECTOR_BYTES * SECTOR_COUNT;
  localparam int          SHIFT = (BUS_BYTES == 4) ? 2 : (BUS_BYTES == 2) ? 1 : 0;
  localparam logic [7:0]  SIZE_LOG = 8'($clog2(TOTAL));
  localparam logic [15:0] LAST_SEC = 16'(SECTOR_COUNT - 1);
  localparam logic [23:0] SEC_LEN  = 24'(SECTOR_BYTES);

  logic [7:0] idx;
  assign idx = addr_lo_i >> SHIFT;

  always_comb begin
    data_o = 8'h00;
    if (idx < QRY_LEN) begin
      case (idx)
        8'h10: data_o = 8'h51;
        8'h11: data_o = 8'h52;
        8'h12: data_o = 8'h59;
        8'h13: data_o = 8'h01;
        8'h15: data_o = 8'h31;
        8'h1B: data_o = 8'h45;
        8'h1C: data_o = 8'h55;
        8'h1F: data_o = 8'h07;
        8'h20: data_o = 8'h07;
        8'h21: data_o = 8'h0A;
        8'h23: data_o = 8'h04;
        8'h24: data_o = 8'h04;
        8'h25: data_o = 8'h04;
        8'h27: data_o = SIZE_LOG;
        8'h28: data_o = 8'h02;
        8'h2A: data_o = 8'h0B;
        8'h2C: data_o = 8'h01;
        8'h2D: data_o = LAST_SEC[7:0];
        8'h2E: data_o = LAST_SEC[15:8];
        8'h2F: data_o = SEC_LEN[15:8];
        8'h30: data_o = SEC_LEN[23:16];
        8'h31: data_o = 8'h50;
        8'h32: data_o = 8'h52;
        8'h33: data_o = 8'h49;
        8'h34: data_o = 8'h31;
        8'h35: data_o = 8'h31;
        default: data_o = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_flash_pkg::*;
#(
  parameter int BUS_BYTES    = 2,
  parameter int SECTOR_BYTES = 256,
  parameter int SECTOR_COUNT = 4,
  parameter int CNT_W        = 8,
  localparam int TOTAL  = SECTOR_BYTES * SECTOR_COUNT,
  localparam int ADDR_W = $clog2(TOTAL)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o
);

  logic       wr, rd;
  phase_e     fsm_phase;
  logic [7:0] fsm_cmd;
  logic [7:0] fsm_status;
  logic       do_prog, do_erase;
  rsel_e      rsel;
  logic [31:0] arr_word;
  logic [7:0]  qry_byte;
  logic [31:0] rdata_d, rdata_q;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  nor_cmd_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .code_i  (wdata_i[7:0]),
    .cnt_i   (wdata_i[CNT_W-1:0]),
    .phase_o (fsm_phase),
    .cmd_o   (fsm_cmd),
    .status_o(fsm_status),
    .prog_o  (do_prog),
    .erase_o (do_erase),
    .rsel_o  (rsel)
  );

  nor_byte_store #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .SECTOR_COUNT(SECTOR_COUNT)
  ) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .prog_i (do_prog),
    .erase_i(do_erase),
    .addr_i (addr_i),
    .size_i (size_i),
    .wdata_i(wdata_i),
    .rd_o   (arr_word)
  );

  nor_query_rom #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .SECTOR_COUNT(SECTOR_COUNT),
    .BUS_BYTES   (BUS_BYTES)
  ) u_query (
    .addr_lo_i(addr_i[7:0]),
    .data_o   (qry_byte)
  );

  always_comb begin
    unique case (rsel)
      RS_ARRAY:  rdata_d = arr_word;
      RS_STATUS: rdata_d = {24'h0, fsm_status};
      RS_QUERY:  rdata_d = {24'h0, qry_byte};
      RS_ONES:   rdata_d = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/nor_flash_chk.sv
module nor_flash_chk
  import nor_flash_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        we_i,
  input logic [7:0]  code_i,
  input logic [31:0] rdata_i,
  input phase_e      phase_i,
  input logic [7:0]  cmd_i,
  input logic [7:0]  status_i
);

  logic idle_wr;
  assign idle_wr = req_i && we_i && (phase_i == PH_IDLE);

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_i)); // R13

  AST_ARRAY_IS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == OP_NULL) |-> (phase_i == PH_IDLE)); // R12

  AST_CLEAR_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_wr && code_i == OP_CLR) |=> (status_i == 8'h00 && cmd_i == OP_NULL)); // R4

  AST_READY_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_i[7] && !(idle_wr && code_i == OP_CLR)) |=> status_i[7]); // R4

  AST_PROG_ONE_SHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && phase_i == PH_ARG && (cmd_i == OP_PROG_A || cmd_i == OP_PROG_B))
    |=> (phase_i == PH_IDLE && status_i[7])); // R2

  AST_STAT_NO_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_wr && code_i == OP_STAT) |=> (phase_i == PH_IDLE && cmd_i == OP_STAT)); // R5

  AST_UNKNOWN_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_wr && !idle_op_known(code_i)) |=> (cmd_i == OP_NULL && $stable(status_i))); // R12

  AST_CONFIRM_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_CONFIRM) |-> (cmd_i == OP_BUF)); // R7

endmodule

bind nor_cmd_flash nor_flash_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .code_i  (wdata_i[7:0]),
  .rdata_i (rdata_o),
  .phase_i (fsm_phase),
  .cmd_i   (fsm_cmd),
  .status_i(fsm_status)
);

// File: tb/nor_cmd_flash_tb_top.sv
`timescale 1ns/1ps
module nor_cmd_flash_tb_top;

  localparam int TOTAL = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;

  always #10 clk = ~clk;

  nor_cmd_flash dut_i (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .req_i  (req),
    .we_i   (we),
    .size_i (size),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata)
  );

  // behavioural reference
  int          mem [TOTAL];
  int          m_phase, m_cmd, m_status, m_cnt;
  logic [31:0] exp_q = '0;
  string       cur_tag = "R1";
  int          checks = 0, fails = 0;
  bit          run = 0, done = 0;

  function automatic int nbytes(int sz);
    return (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
  endfunction

  function automatic int qtab(int idx);
    case (idx)
      'h10: return 'h51; 'h11: return 'h52; 'h12: return 'h59;
      'h13: return 'h01; 'h15: return 'h31;
      'h1B: return 'h45; 'h1C: return 'h55;
      'h1F: return 'h07; 'h20: return 'h07; 'h21: return 'h0A;
      'h23: return 'h04; 'h24: return 'h04; 'h25: return 'h04;
      'h27: return 10;   'h28: return 'h02; 'h2A: return 'h0B;
      'h2C: return 'h01; 'h2D: return 3;    'h2F: return 1;
      'h31: return 'h50; 'h32: return 'h52; 'h33: return 'h49;
      'h34: return 'h31; 'h35: return 'h31;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(int a, int sz);
    logic [31:0] r = '0;
    if (m_cmd == 0) begin
      for (int k = 0; k < nbytes(sz); k++) r |= 32'(mem[(a + k) % TOTAL]) << (8 * k);
    end else if (m_cmd == 'h20 || m_cmd == 'h60 || m_cmd == 'h70 || m_cmd == 'hE8) begin
      r = 32'(m_status);
    end else if (m_cmd == 'h98) begin
      int idx = (a & 255) >> 1;
      r = (idx >= 'h52) ? 32'h0 : 32'(qtab(idx));
    end else begin
      r = 32'hFFFF_FFFF;
    end
    return r;
  endfunction

  task automatic m_store(int a, int sz, logic [31:0] v);
    for (int k = 0; k < nbytes(sz); k++) mem[(a + k) % TOTAL] = int'((v >> (8 * k)) & 32'hFF);
  endtask

  task automatic m_abort();
    m_cmd = 0;
    m_phase = 0;
  endtask

  task automatic m_write(int a, int sz, logic [31:0] v);
    int c = int'(v & 32'hFF);
    case (m_phase)
      0: begin
        if (c == 'h10 || c == 'h40 || c == 'h60 || c == 'h98) begin m_cmd = c; m_phase = 1; end
        else if (c == 'h20) begin
          for (int b = a & ~255; b < (a & ~255) + 256; b++) mem[b] = 'hFF;
          m_status |= 'h80; m_cmd = c; m_phase = 1;
        end
        else if (c == 'hE8) begin m_status |= 'h80; m_cmd = c; m_phase = 1; end
        else if (c == 'h50) begin m_status = 0; m_abort(); end
        else if (c == 'h70) m_cmd = c;
        else m_abort();
      end
      1: begin
        if (m_cmd == 'h10 || m_cmd == 'h40) begin m_store(a, sz, v); m_status |= 'h80; m_abort(); end
        else if (m_cmd == 'h20) begin
          if (c == 'hD0) begin m_phase = 0; m_status |= 'h80; end else m_abort();
        end
        else if (m_cmd == 'h60) begin
          if (c == 'hD0 || c == 'h01) begin m_phase = 0; m_status |= 'h80; end else m_abort();
        end
        else if (m_cmd == 'h98) begin if (c == 'hFF) m_abort(); end
        else if (m_cmd == 'hE8) begin m_cnt = c; m_phase = 2; end
        else m_abort();
      end
      2: begin
        m_store(a, sz, v); m_status |= 'h80;
        if (m_cnt == 0) m_phase = 3;
        m_cnt = m_cnt - 1;
      end
      default: begin
        if (c == 'hD0) begin m_phase = 0; m_status |= 'h80; end else m_abort();
      end
    endcase
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (run && !done) begin
      checks++;
      if (rdata !== exp_q) begin
        fails++;
        $display("FAIL %s rdata=%h expected=%h at %0t", cur_tag, rdata, exp_q, $time);
      end
    end
  end

  task automatic op(bit w, int sz, int a, logic [31:0] v, string tag);
    logic [31:0] pred = '0;
    req = 1'b1; we = w; size = 2'(sz); addr = 10'(a); wdata = v;
    if (w) m_write(a, sz, v);
    else pred = m_read(a, sz);
    @(posedge clk);
    if (!w) begin exp_q = pred; cur_tag = tag; end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic wr(int a, logic [31:0] v, string tag);
    op(1, 0, a, v, tag);
  endtask

  task automatic wrs(int a, int sz, logic [31:0] v, string tag);
    op(1, sz, a, v, tag);
  endtask

  task automatic rd(int a, int sz, string tag);
    op(0, sz, a, 32'h0, tag);
  endtask

  task automatic idle(int n, string tag);
    cur_tag = tag;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < TOTAL; i++) mem[i] = 'hFF;
    m_phase = 0; m_cmd = 0; m_status = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run = 1;
    idle(2, "R1");

    // R1 reset contents and status
    rd(0, 0, "R1"); rd('h100, 1, "R1"); rd('h3FC, 2, "R1");
    wr(0, 'h70, "R1"); rd(0, 0, "R1"); wr(0, 'hFF, "R1");

    // R2 / R11 program and little-endian lanes
    wr('h10, 'h40, "R2"); rd('h10, 2, "R2");
    wrs('h10, 1, 32'hCAFE_A55A, "R2");
    rd('h10, 0, "R11"); rd('h11, 0, "R11"); rd('h10, 2, "R11"); rd('h10, 1, "R11");
    wr('h20, 'h10, "R2"); wrs('h20, 2, 32'h1234_5678, "R2");
    rd('h20, 2, "R11"); rd('h22, 1, "R11"); rd('h23, 0, "R11");
    wr('h104, 'h40, "R2"); wrs('h104, 3, 32'hDEAD_BEEF, "R2"); rd('h104, 3, "R11");
    wr(0, 'h70, "R8"); rd(0, 2, "R8"); idle(3, "R13"); rd(2, 0, "R8");

    // R4 clear status
    wr(0, 'h50, "R4"); rd('h10, 1, "R4"); wr(0, 'h70, "R4"); rd(0, 0, "R4");
    wr(0, 'h00, "R5"); rd('h20, 2, "R5");

    // R3 erase: confirm, abort with FF, abort with unknown
    wr('h15, 'h20, "R3"); rd('h10, 1, "R3"); wr('h15, 'hD0, "R3"); rd(0, 0, "R3");
    wr(0, 'hFF, "R3"); rd('h10, 2, "R3"); rd('h20, 2, "R3"); rd('h104, 2, "R3");
    wr(0, 'h50, "R4");
    wr('h105, 'h20, "R3"); rd(0, 0, "R3"); wr('h105, 'h33, "R3"); rd('h104, 2, "R3");
    wr('h10, 'h40, "R2"); wrs('h10, 1, 32'h0000_BEEF, "R2");
    wr('h2FF, 'h20, "R3"); wr(0, 'hFF, "R3"); rd('h10, 1, "R3"); rd('h2FC, 2, "R3");

    // R6 lock sequences
    wr(0, 'h50, "R4");
    wr('h10, 'h60, "R6"); rd(0, 0, "R6"); wr('h10, 'hD0, "R6"); rd(0, 0, "R6");
    wr(0, 'h50, "R4");
    wr('h10, 'h60, "R6"); wr('h10, 'h01, "R6"); rd(0, 0, "R6");
    wr('h10, 'h60, "R6"); wr('h10, 'hFF, "R6"); rd('h10, 1, "R6");
    wr('h10, 'h60, "R6"); wr('h10, 'h77, "R6"); rd('h10, 1, "R6");

    // R7 buffered write, count 3, confirmed
    wr(0, 'h50, "R4");
    wr('h200, 'hE8, "R7"); rd(0, 0, "R7");
    wr('h200, 3, "R7");
    wrs('h200, 1, 32'h1111, "R7"); wrs('h202, 1, 32'h2222, "R7");
    wrs('h204, 1, 32'h3333, "R7"); rd(0, 0, "R7");
    wrs('h206, 1, 32'h4444, "R7");
    wr('h200, 'hD0, "R7"); rd(0, 0, "R7"); wr(0, 'hFF, "R7");
    rd('h200, 2, "R7"); rd('h204, 2, "R7"); rd('h208, 1, "R7");
    // count 0, bad confirm
    wr('h300, 'hE8, "R7"); wr('h300, 0, "R7"); wrs('h300, 1, 32'h00AB, "R7");
    wr('h300, 'h12, "R7"); rd('h300, 1, "R7"); rd('h302, 1, "R7");
    // count 1 then confirm value D0 seen as data (phase must still be data)
    wr('h310, 'hE8, "R7"); wr('h310, 1, "R7"); wrs('h310, 1, 32'h00D0, "R7");
    rd(0, 0, "R7"); wrs('h312, 1, 32'h00D0, "R7"); wr(0, 'hD0, "R7"); rd(0, 0, "R7");
    wr(0, 'hFF, "R7"); rd('h310, 2, "R7");

    // R9 / R10 query
    wr(0, 'h98, "R9");
    for (int i = 'h20; i < 'hA8; i += 2) rd(i, 1, "R10");
    rd('hA4, 0, "R9"); rd('hFE, 1, "R9"); rd('h21, 0, "R9");
    wr(0, 'h12, "R9"); rd('h22, 1, "R9");
    wr(0, 'hFF, "R9"); rd('h20, 2, "R9");

    // R12 unknown codes
    wr(0, 'h50, "R4"); wr(0, 'h70, "R12"); rd(0, 0, "R12");
    wr(0, 'h33, "R12"); rd('h200, 1, "R12");
    wr(0, 'h40, "R2"); wrs(0, 0, 32'h5A, "R2");
    wr(0, 'hC3, "R12"); rd(0, 0, "R12"); wr(0, 'h70, "R12"); rd(0, 0, "R12");
    wr(0, 'hFF, "R5"); rd(0, 0, "R5");
    idle(4, "R13");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL R13 watchdog expired rdata=%h expected=%h", rdata, exp_q);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule